// File: doc/BRIEF.md
# Operand Bypass and Interlock Controller

This block decides, for every source operand of the instruction sitting in the operand-read stage of a five-stage scalar pipeline (fetch, decode, operand read, execute, write back), where that operand must come from. It keeps a small record of the two older instructions in the execute and write-back stages: their destination register, whether they write at all, and whether the execute-stage one is a load. The operand multiplexer can take the register file, the ALU output of the execute stage, or the value the write-back stage is committing. That last value is either load data returning from the data cache or a latched ALU result.

A load in execute has no data yet. A consumer of it right behind is therefore held for one cycle: the controller lowers its ready, and a no-operation bubble goes into the execute stage in place of the held instruction. On the next cycle the load is in write back and its data is bypassed. With the single-port register file variant, a register-file read in the same cycle as a write-back write also holds the reader. This rule applies only when the reader actually needs the register file.

The operand-read stage presents its instruction as a valid/ready stream. An instruction issues into execute on a cycle where valid and ready are both high. While valid is high and ready is low, the operand-read, decode and fetch registers hold, and the descriptor must stay unchanged. Ready is high whenever valid is low. The stages after operand read never push back.

Top module: `fwd_interlock_unit`

## Requirements
- R1: After reset the execute and write-back records are empty: ready is 1, every operand select is 0 (register file) and the bubble flag is 0.
- R2: A used source equal to the destination of a writing, non-load instruction in execute gets select 1 (ALU bypass), with no stall.
- R3: A used source equal to the destination of a writing instruction in write back, load or not, gets select 2 (write-back bypass), with no stall.
- R4: When the execute and write-back instructions both match the same source, the execute-stage match wins and the select is 1.
- R5: A used source matching a load in execute drops ready for exactly one cycle. If the descriptor is held, the next cycle has ready 1 and select 2 for that source.
- R6: The cycle after a held valid instruction, the bubble flag is 1, and the bubble never acts as a forwarding source.
- R7: Register 0 as destination, a deasserted write enable, or a source whose use bit is 0 never causes forwarding (select stays 0) or a stall.
- R8: With the single-port variant, a writing instruction in write back together with a used source that needs the register file drops ready. A source served by a bypass does not do this. The dual-port variant never stalls for this reason.
- R9: An invalid descriptor never stalls and never enters the execute record. A later matching source gets no forwarding from it, and no bubble flag is raised for it.
- R10: Each source is resolved on its own. One source can take the ALU bypass while the other takes the write-back bypass in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| of_valid_i | input | 1 | Operand-read stage holds an instruction |
| of_ready_o | output | 1 | Instruction may issue into execute this cycle |
| of_src_i | input | NUM_SRC*REG_AW | Source register indices, source k at bits k*REG_AW upward |
| of_src_use_i | input | NUM_SRC | Source k is actually read |
| of_rd_i | input | REG_AW | Destination register of the instruction |
| of_we_i | input | 1 | Instruction writes its destination |
| of_load_i | input | 1 | Instruction is a load |
| opnd_sel_o | output | NUM_SRC*2 | Per-source select: 0 register file, 1 ALU bypass, 2 write-back bypass |
| ex_nop_o | output | 1 | Execute stage holds an injected bubble |

## Verification
A corrupted execute or write-back record shows up on the very next operand-read cycle as a wrong select code on a dependent source. Each scenario therefore issues a producer and then probes with a consumer one or two cycles later. A wrong stall decision shows at once on ready. A wrong bubble shows one cycle later on the bubble flag and two cycles later as a stale forward. The load-use and port-conflict sequences follow ready and the selects across every held cycle until the instruction issues.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_RF  = 2'd0,
    SEL_ALU = 2'd1,
    SEL_WB  = 2'd2
  } opsel_e;
endpackage

// File: rtl/fwd_stage_track.sv
module fwd_stage_track #(
  parameter int REG_AW = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  logic              bubble_i,
  input  logic [REG_AW-1:0] of_rd_i,
  input  logic              of_we_i,
  input  logic              of_load_i,
  output logic              ex_wr_o,
  output logic              ex_ld_o,
  output logic [REG_AW-1:0] ex_rd_o,
  output logic              ex_nop_o,
  output logic              wb_wr_o,
  output logic [REG_AW-1:0] wb_rd_o
);
  logic              ex_wr_q, ex_ld_q, ex_nop_q, wb_wr_q;
  logic [REG_AW-1:0] ex_rd_q, wb_rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ex_wr_q  <= 1'b0;
      ex_ld_q  <= 1'b0;
      ex_nop_q <= 1'b0;
      ex_rd_q  <= '0;
      wb_wr_q  <= 1'b0;
      wb_rd_q  <= '0;
    end else begin
      wb_wr_q <= ex_wr_q;
      wb_rd_q <= ex_rd_q;
      if (issue_i) begin
        ex_wr_q  <= of_we_i && (of_rd_i != '0);
        ex_ld_q  <= of_load_i;
        ex_rd_q  <= of_rd_i;
        ex_nop_q <= 1'b0;
      end else begin
        ex_wr_q  <= 1'b0;
        ex_ld_q  <= 1'b0;
        ex_rd_q  <= '0;
        ex_nop_q <= bubble_i;
      end
    end
  end

  assign ex_wr_o  = ex_wr_q;
  assign ex_ld_o  = ex_ld_q;
  assign ex_rd_o  = ex_rd_q;
  assign ex_nop_o = ex_nop_q;
  assign wb_wr_o  = wb_wr_q;
  assign wb_rd_o  = wb_rd_q;

  // R6: an injected bubble hands no writer to write back
  assert_bubble_inert_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ex_nop_q |=> !wb_wr_q);
endmodule

// File: rtl/fwd_src_match.sv
module fwd_src_match import fwd_pkg::*; #(
  parameter int REG_AW = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] src_i,
  input  logic              use_i,
  input  logic              ex_wr_i,
  input  logic              ex_ld_i,
  input  logic [REG_AW-1:0] ex_rd_i,
  input  logic              wb_wr_i,
  input  logic [REG_AW-1:0] wb_rd_i,
  output opsel_e            sel_o,
  output logic              ld_stall_o,
  output logic              rf_read_o
);
  logic ex_hit, wb_hit;

  assign ex_hit = use_i && ex_wr_i && (ex_rd_i == src_i);
  assign wb_hit = use_i && wb_wr_i && (wb_rd_i == src_i);

  always_comb begin
    sel_o      = SEL_RF;
    ld_stall_o = 1'b0;
    rf_read_o  = 1'b0;
    if (ex_hit) begin
      if (ex_ld_i) ld_stall_o = 1'b1;
      else         sel_o      = SEL_ALU;
    end else if (wb_hit) begin
      sel_o = SEL_WB;
    end else begin
      rf_read_o = use_i;
    end
  end

  // R7: an unused source or register 0 is never bypassed nor stalled
  assert_idle_src_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!use_i || src_i == '0) |-> (sel_o == SEL_RF && !ld_stall_o));
endmodule

// File: rtl/fwd_issue_ctl.sv
module fwd_issue_ctl #(
  parameter int NUM_SRC     = 2,
  parameter bit SHARED_PORT = 1'b0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               of_valid_i,
  input  logic [NUM_SRC-1:0] ld_stall_i,
  input  logic [NUM_SRC-1:0] rf_read_i,
  input  logic               wb_wr_i,
  output logic               of_ready_o,
  output logic               issue_o,
  output logic               bubble_o
);
  logic port_clash;
  logic hazard;

  generate
    if (SHARED_PORT) begin : g_shared
      assign port_clash = wb_wr_i && (|rf_read_i);
    end else begin : g_dual
      assign port_clash = 1'b0;
      // R5: with two ports a stall never lasts beyond one cycle
      assert_single_stall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !of_ready_o |=> of_ready_o);
    end
  endgenerate

  assign hazard     = (|ld_stall_i) || port_clash;
  assign of_ready_o = !(of_valid_i && hazard);
  assign issue_o    = of_valid_i && !hazard;
  assign bubble_o   = of_valid_i && hazard;
endmodule

// File: rtl/fwd_interlock_unit.sv
module fwd_interlock_unit import fwd_pkg::*; #(
  parameter int REG_AW      = 5,
  parameter int NUM_SRC     = 2,
  parameter bit SHARED_PORT = 1'b0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     of_valid_i,
  output logic                     of_ready_o,
  input  logic [NUM_SRC*REG_AW-1:0] of_src_i,
  input  logic [NUM_SRC-1:0]       of_src_use_i,
  input  logic [REG_AW-1:0]        of_rd_i,
  input  logic                     of_we_i,
  input  logic                     of_load_i,
  output logic [NUM_SRC*SEL_W-1:0] opnd_sel_o,
  output logic                     ex_nop_o
);
  logic              issue, bubble;
  logic              ex_wr, ex_ld, wb_wr;
  logic [REG_AW-1:0] ex_rd, wb_rd;
  logic [NUM_SRC-1:0] ld_stall, rf_read, alu_pick;

  fwd_stage_track #(.REG_AW(REG_AW)) u_track (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .issue_i   (issue),
    .bubble_i  (bubble),
    .of_rd_i   (of_rd_i),
    .of_we_i   (of_we_i),
    .of_load_i (of_load_i),
    .ex_wr_o   (ex_wr),
    .ex_ld_o   (ex_ld),
    .ex_rd_o   (ex_rd),
    .ex_nop_o  (ex_nop_o),
    .wb_wr_o   (wb_wr),
    .wb_rd_o   (wb_rd)
  );

  generate
    for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
      opsel_e sel;
      fwd_src_match #(.REG_AW(REG_AW)) u_match (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .src_i      (of_src_i[k*REG_AW +: REG_AW]),
        .use_i      (of_src_use_i[k]),
        .ex_wr_i    (ex_wr),
        .ex_ld_i    (ex_ld),
        .ex_rd_i    (ex_rd),
        .wb_wr_i    (wb_wr),
        .wb_rd_i    (wb_rd),
        .sel_o      (sel),
        .ld_stall_o (ld_stall[k]),
        .rf_read_o  (rf_read[k])
      );
      assign opnd_sel_o[k*SEL_W +: SEL_W] = sel;
      assign alu_pick[k] = (sel == SEL_ALU);
    end
  endgenerate

  fwd_issue_ctl #(.NUM_SRC(NUM_SRC), .SHARED_PORT(SHARED_PORT)) u_issue (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .of_valid_i (of_valid_i),
    .ld_stall_i (ld_stall),
    .rf_read_i  (rf_read),
    .wb_wr_i    (wb_wr),
    .of_ready_o (of_ready_o),
    .issue_o    (issue),
    .bubble_o   (bubble)
  );

  // R6: a held valid instruction leaves a bubble in execute
  assert_bubble_injected_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (of_valid_i && !of_ready_o) |=> ex_nop_o);

  // R2: the ALU bypass is never chosen while a load occupies execute
  assert_alu_not_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|alu_pick) |-> !ex_ld);

  // R9: an empty operand-read stage is never held
  assert_idle_ready_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !of_valid_i |-> of_ready_o);
endmodule

// File: tb/fwd_interlock_unit_bench.sv
module fwd_interlock_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       v;
  logic [9:0] src;
  logic [1:0] use_b;
  logic [4:0] rd;
  logic       we, ld;
  logic       a_rdy, b_rdy, a_nop, b_nop;
  logic [3:0] a_sel, b_sel;
  logic       sa_rdy, sb_rdy, sa_nop, sb_nop;
  logic [3:0] sa_sel, sb_sel;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  fwd_interlock_unit u_fwd_interlock_unit (
    .clk_i(clk), .rst_ni(rst_n), .of_valid_i(v), .of_ready_o(a_rdy),
    .of_src_i(src), .of_src_use_i(use_b), .of_rd_i(rd), .of_we_i(we),
    .of_load_i(ld), .opnd_sel_o(a_sel), .ex_nop_o(a_nop));

  fwd_interlock_unit #(.SHARED_PORT(1'b1)) u_shared (
    .clk_i(clk), .rst_ni(rst_n), .of_valid_i(v), .of_ready_o(b_rdy),
    .of_src_i(src), .of_src_use_i(use_b), .of_rd_i(rd), .of_we_i(we),
    .of_load_i(ld), .opnd_sel_o(b_sel), .ex_nop_o(b_nop));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic ck(input string req, input int act, input int exp);
    check(act == exp, req, act, exp);
  endtask

  // drive one operand-read cycle and sample the outputs before the next edge
  task automatic step(input logic vv, input logic [4:0] s0, input logic [4:0] s1,
                      input logic u0, input logic u1, input logic [4:0] d,
                      input logic w, input logic l);
    @(negedge clk);
    v = vv; src = {s1, s0}; use_b = {u1, u0}; rd = d; we = w; ld = l;
    #1;
    sa_rdy = a_rdy; sa_nop = a_nop; sa_sel = a_sel;
    sb_rdy = b_rdy; sb_nop = b_nop; sb_sel = b_sel;
  endtask

  task automatic flush;
    step(0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_reset;
    step(0, 0, 0, 0, 0, 0, 0, 0);
    ck("R1 ready", sa_rdy, 1);
    ck("R1 sel", sa_sel, 0);
    ck("R1 nop", sa_nop, 0);
  endtask

  task automatic t_alu_ex;
    flush;
    step(1, 1, 2, 1, 1, 3, 1, 0);
    step(1, 3, 4, 1, 1, 20, 0, 0);
    ck("R2 sel0", sa_sel[1:0], 1);
    ck("R2 sel1", sa_sel[3:2], 0);
    ck("R2 ready", sa_rdy, 1);
  endtask

  task automatic t_wb;
    flush;
    step(1, 1, 2, 1, 1, 5, 1, 0);
    step(1, 1, 2, 1, 1, 6, 1, 0);
    step(1, 5, 1, 1, 1, 0, 0, 0);
    ck("R3 alu sel0", sa_sel[1:0], 2);
    ck("R3 alu sel1", sa_sel[3:2], 0);
    flush;
    step(1, 1, 2, 1, 1, 7, 1, 1);
    step(1, 1, 2, 1, 1, 6, 1, 0);
    step(1, 3, 7, 1, 1, 0, 0, 0);
    ck("R3 load sel1", sa_sel[3:2], 2);
    ck("R3 load ready", sa_rdy, 1);
  endtask

  task automatic t_prio;
    flush;
    step(1, 1, 2, 1, 1, 8, 1, 0);
    step(1, 1, 2, 1, 1, 8, 1, 0);
    step(1, 8, 0, 1, 0, 0, 0, 0);
    ck("R4 sel0", sa_sel[1:0], 1);
  endtask

  task automatic t_load_use;
    flush;
    step(1, 1, 2, 1, 1, 9, 1, 1);
    step(1, 9, 2, 1, 1, 10, 1, 0);
    ck("R5 stall ready", sa_rdy, 0);
    ck("R5 stall nop", sa_nop, 0);
    ck("R5 stall sel1", sa_sel[3:2], 0);
    step(1, 9, 2, 1, 1, 10, 1, 0);
    ck("R5 resume ready", sa_rdy, 1);
    ck("R5 resume sel0", sa_sel[1:0], 2);
    ck("R6 bubble flag", sa_nop, 1);
    step(1, 9, 10, 1, 1, 0, 0, 0);
    ck("R6 no stale fwd sel0", sa_sel[1:0], 0);
    ck("R6 issued fwd sel1", sa_sel[3:2], 1);
    ck("R6 nop cleared", sa_nop, 0);
  endtask

  task automatic t_ignore;
    flush;
    step(1, 1, 2, 1, 1, 0, 1, 0);
    step(1, 0, 0, 1, 1, 0, 0, 0);
    ck("R7 r0 sel", sa_sel, 0);
    ck("R7 r0 ready", sa_rdy, 1);
    flush;
    step(1, 1, 2, 1, 1, 11, 0, 1);
    step(1, 11, 0, 1, 0, 0, 0, 0);
    ck("R7 we0 ready", sa_rdy, 1);
    ck("R7 we0 sel0", sa_sel[1:0], 0);
    flush;
    step(1, 1, 2, 1, 1, 12, 1, 1);
    step(1, 12, 0, 0, 0, 0, 0, 0);
    ck("R7 unused ready", sa_rdy, 1);
    ck("R7 unused sel0", sa_sel[1:0], 0);
  endtask

  task automatic t_invalid;
    flush;
    step(0, 1, 2, 1, 1, 13, 1, 1);
    step(1, 13, 0, 1, 0, 0, 0, 0);
    ck("R9 no entry sel0", sa_sel[1:0], 0);
    ck("R9 no entry ready", sa_rdy, 1);
    flush;
    step(1, 1, 2, 1, 1, 14, 1, 1);
    step(0, 14, 0, 1, 0, 0, 0, 0);
    ck("R9 invalid ready", sa_rdy, 1);
    step(1, 14, 0, 1, 0, 0, 0, 0);
    ck("R9 later sel0", sa_sel[1:0], 2);
    ck("R9 no bubble", sa_nop, 0);
  endtask

  task automatic t_two_src;
    flush;
    step(1, 1, 2, 1, 1, 15, 1, 0);
    step(1, 1, 2, 1, 1, 16, 1, 0);
    step(1, 16, 15, 1, 1, 0, 0, 0);
    ck("R10 sel0", sa_sel[1:0], 1);
    ck("R10 sel1", sa_sel[3:2], 2);
  endtask

  task automatic t_shared;
    flush;
    step(1, 1, 2, 1, 1, 17, 1, 0);
    step(1, 1, 2, 1, 1, 18, 1, 0);
    ck("R8 no clash yet", sb_rdy, 1);
    step(1, 19, 0, 1, 0, 0, 0, 0);
    ck("R8 clash ready", sb_rdy, 0);
    ck("R8 dual no clash", sa_rdy, 1);
    ck("R8 dual sel0", sa_sel[1:0], 0);
    step(1, 19, 0, 1, 0, 0, 0, 0);
    ck("R8 second clash", sb_rdy, 0);
    ck("R8 bubble", sb_nop, 1);
    step(1, 19, 0, 1, 0, 0, 0, 0);
    ck("R8 released", sb_rdy, 1);
    flush;
    step(1, 1, 2, 1, 1, 17, 1, 0);
    step(1, 1, 2, 1, 1, 18, 1, 0);
    step(1, 17, 0, 1, 0, 0, 0, 0);
    ck("R8 bypass only ready", sb_rdy, 1);
    ck("R8 bypass only sel0", sb_sel[1:0], 2);
  endtask

  initial begin
    v = 0; src = '0; use_b = '0; rd = '0; we = 0; ld = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    t_reset;
    t_alu_ex;
    t_wb;
    t_prio;
    t_load_use;
    t_ignore;
    t_invalid;
    t_two_src;
    t_shared;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    checks++;
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule